// File: doc/BRIEF.md
# Snooping Three-State Coherence Controller

This block is the coherence controller that sits beside one direct-mapped, write-back cache on a shared snooping bus. It keeps a tag, one data word and a coherence state for every line. It serves a single processor port, and it asks an external arbiter for the bus whenever it must place a command there: a read miss, a write miss or the write-back of a dirty victim.

It also watches every transaction that the other caches place on the bus. When such a transaction names a block that this cache holds, the controller invalidates or downgrades its copy. When its copy is the only dirty one, it supplies the data and tells memory to abandon the access.

Processor-side changes and snoop-side changes act on the same state array. No processor miss changes the line until the bus has been granted. A snoop that touches the pending line while the controller waits for the grant is applied first, and the processor request is then evaluated again from the start.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid (state codes: 0 Invalid, 1 Shared, 2 Exclusive). The first read of any address therefore goes to the bus, and `cpu_done_o`, `bus_req_o` and `snp_abort_o` are low.
- R2: A processor read that misses issues a read-miss command for the requested address. The line becomes Shared, holding the data returned on `bus_rdata_i`, so a later read of that address hits.
- R3: A processor write to a line that is not Exclusive, whether it is Invalid, Shared with the same tag, or holds another tag, issues a write-miss command. The line then becomes Exclusive and holds the written word.
- R4: A miss whose line holds a different block in the Exclusive state first issues a write-back of that block, with its address and its dirty word. Only after that write-back has been granted does it issue the read-miss or write-miss command.
- R5: A read hit on a Shared or Exclusive line, and a write hit on an Exclusive line, complete in the cycle the request is presented and raise no bus request.
- R6: A snooped write miss that matches a Shared line invalidates it without asserting `snp_abort_o`.
- R7: A snooped read miss that matches an Exclusive line asserts `snp_abort_o` in that cycle and drives the line's word on `snp_data_o`. The line becomes Shared.
- R8: A snooped write miss that matches an Exclusive line asserts `snp_abort_o` with the line's word on `snp_data_o`. The line becomes Invalid.
- R9: The line is written only in a grant cycle. If a snoop changes the pending line while the controller waits for the grant, the controller drops its request and re-evaluates the processor request against the new state. A victim downgraded by the snoop is then not written back again.
- R10: If a snoop changes the line at the same index as a processor request in the same cycle, the snoop is applied and the processor access does not complete in that cycle.
- R11: Bus commands use 2-bit codes: 0 none, 1 read miss, 2 write miss, 3 write-back. `bus_addr_o` carries the block address as the tag above the index. A miss completes with `cpu_done_o` in its grant cycle, and for a read, `cpu_rdata_o` equals `bus_rdata_i`.
- R12: A snoop is ignored and the line is left unchanged when its tag differs from the line's, when the line is Invalid, when its command is none or write-back, or when it is a read miss to a Shared line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held with its fields until `cpu_done_o` |
| cpu_we_i | input | 1 | 1 for a write, 0 for a read |
| cpu_addr_i | input | ADDR_W | Block address (tag above index) |
| cpu_wdata_i | input | DATA_W | Write word |
| cpu_rdata_o | output | DATA_W | Read word, valid with `cpu_done_o` |
| cpu_done_o | output | 1 | Request completes this cycle |
| bus_req_o | output | 1 | Request to the bus arbiter |
| bus_gnt_i | input | 1 | Grant; the command is performed in this cycle |
| bus_cmd_o | output | 2 | Bus command code |
| bus_addr_o | output | ADDR_W | Block address of the command |
| bus_wdata_o | output | DATA_W | Write-back word |
| bus_rdata_i | input | DATA_W | Fill word for a miss, valid in the grant cycle |
| snp_cmd_i | input | 2 | Command placed on the bus by another cache |
| snp_addr_i | input | ADDR_W | Block address of the snooped command |
| snp_abort_o | output | 1 | This cache owns the block: memory must abandon the access |
| snp_data_o | output | DATA_W | Dirty word supplied with `snp_abort_o` |

## Verification
Two functions can fall in the same cycle: a snoop that changes a line, and a processor access to the same index. The snoop may arrive in the very cycle a request is first presented, or in a cycle where the controller is waiting for the grant with a victim write-back or a miss outstanding. The bench injects snoops at both of those points, at chosen and at random addresses. Its reference model applies the snoop before the processor request. Each outcome is judged on the abort output, on the exact list of commands granted on the bus, on the completion cycle and on the returned word.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {LS_I = 2'd0, LS_S = 2'd1, LS_E = 2'd2} line_st_e;
  typedef enum logic [1:0] {BC_NONE = 2'd0, BC_RDMISS = 2'd1, BC_WRMISS = 2'd2, BC_WBACK = 2'd3} bus_cmd_e;
  typedef enum logic [1:0] {F_IDLE = 2'd0, F_WBACK = 2'd1, F_MISS = 2'd2} ctl_st_e;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  localparam int LINES = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  line_st_e          wr_st_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              snp_en_i,
  input  logic [IDX_W-1:0]  snp_idx_i,
  input  line_st_e          snp_st_i,
  input  logic [IDX_W-1:0]  cpu_idx_i,
  output line_st_e          cpu_st_o,
  output logic [TAG_W-1:0]  cpu_tag_o,
  output logic [DATA_W-1:0] cpu_data_o,
  output line_st_e          snp_st_o,
  output logic [TAG_W-1:0]  snp_tag_o,
  output logic [DATA_W-1:0] snp_data_o,
  output line_st_e          st_o [LINES]
);
  logic [TAG_W-1:0]  tag_all  [LINES];
  logic [DATA_W-1:0] data_all [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_st_e          st_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q   <= LS_I;
        tag_q  <= '0;
        data_q <= '0;
      end else begin
        if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
          st_q   <= wr_st_i;
          tag_q  <= wr_tag_i;
          data_q <= wr_data_i;
        end
        // snoop wins the state field
        if (snp_en_i && snp_idx_i == IDX_W'(g)) st_q <= snp_st_i;
      end
    end

    assign st_o[g]     = st_q;
    assign tag_all[g]  = tag_q;
    assign data_all[g] = data_q;
  end

  assign cpu_st_o   = st_o[cpu_idx_i];
  assign cpu_tag_o  = tag_all[cpu_idx_i];
  assign cpu_data_o = data_all[cpu_idx_i];
  assign snp_st_o   = st_o[snp_idx_i];
  assign snp_tag_o  = tag_all[snp_idx_i];
  assign snp_data_o = data_all[snp_idx_i];
endmodule

// File: rtl/msi_snoop_logic.sv
module msi_snoop_logic
  import msi_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  bus_cmd_e         cmd_i,
  input  logic [TAG_W-1:0] tag_i,
  input  line_st_e         line_st_i,
  input  logic [TAG_W-1:0] line_tag_i,
  output logic             chg_o,
  output line_st_e         new_st_o,
  output logic             abort_o
);
  logic match;
  assign match = (line_st_i != LS_I) && (line_tag_i == tag_i);

  always_comb begin
    chg_o    = 1'b0;
    new_st_o = line_st_i;
    abort_o  = 1'b0;
    unique case (cmd_i)
      BC_RDMISS: if (match && line_st_i == LS_E) begin
        chg_o    = 1'b1;
        new_st_o = LS_S;
        abort_o  = 1'b1;
      end
      BC_WRMISS: if (match) begin
        chg_o    = 1'b1;
        new_st_o = LS_I;
        abort_o  = (line_st_i == LS_E);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_done_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic [1:0]        snp_cmd_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_abort_o,
  output logic [DATA_W-1:0] snp_data_o
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  logic [IDX_W-1:0] cpu_idx, snp_idx;
  logic [TAG_W-1:0] cpu_tag, snp_tag;
  assign cpu_idx = cpu_addr_i[IDX_W-1:0];
  assign cpu_tag = cpu_addr_i[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr_i[IDX_W-1:0];
  assign snp_tag = snp_addr_i[ADDR_W-1:IDX_W];

  line_st_e          cl_st, sl_st, snp_new_st, wr_st;
  logic [TAG_W-1:0]  cl_tag, sl_tag, wr_tag;
  logic [DATA_W-1:0] cl_data, sl_data, wr_data;
  line_st_e          line_st [LINES];
  logic              wr_en, snp_chg, snp_abort;

  msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(cpu_idx), .wr_tag_i(wr_tag), .wr_st_i(wr_st), .wr_data_i(wr_data),
    .snp_en_i(snp_chg), .snp_idx_i(snp_idx), .snp_st_i(snp_new_st),
    .cpu_idx_i(cpu_idx), .cpu_st_o(cl_st), .cpu_tag_o(cl_tag), .cpu_data_o(cl_data),
    .snp_st_o(sl_st), .snp_tag_o(sl_tag), .snp_data_o(sl_data), .st_o(line_st)
  );

  msi_snoop_logic #(.TAG_W(TAG_W)) i_snoop (
    .cmd_i(bus_cmd_e'(snp_cmd_i)), .tag_i(snp_tag), .line_st_i(sl_st), .line_tag_i(sl_tag),
    .chg_o(snp_chg), .new_st_o(snp_new_st), .abort_o(snp_abort)
  );

  assign snp_abort_o = snp_abort;
  assign snp_data_o  = snp_abort ? sl_data : '0;

  // snoop touching the line the processor is working on
  logic snp_pend, tag_eq, hit, victim_dirty;
  assign snp_pend     = snp_chg && (snp_idx == cpu_idx);
  assign tag_eq       = (cl_tag == cpu_tag);
  assign hit          = cpu_we_i ? (cl_st == LS_E && tag_eq) : (cl_st != LS_I && tag_eq);
  assign victim_dirty = (cl_st == LS_E) && !tag_eq;

  ctl_st_e fsm_q, fsm_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fsm_q <= F_IDLE;
    else         fsm_q <= fsm_d;
  end

  always_comb begin
    fsm_d       = fsm_q;
    cpu_done_o  = 1'b0;
    cpu_rdata_o = '0;
    bus_req_o   = 1'b0;
    bus_cmd_o   = BC_NONE;
    bus_addr_o  = '0;
    bus_wdata_o = '0;
    wr_en       = 1'b0;
    wr_st       = cl_st;
    wr_tag      = cl_tag;
    wr_data     = cl_data;
    unique case (fsm_q)
      F_IDLE: if (cpu_req_i && !snp_pend) begin
        if (hit) begin
          cpu_done_o  = 1'b1;
          cpu_rdata_o = cl_data;
          if (cpu_we_i) begin
            wr_en   = 1'b1;
            wr_data = cpu_wdata_i;
          end
        end else begin
          fsm_d = victim_dirty ? F_WBACK : F_MISS;
        end
      end
      F_WBACK: begin
        bus_req_o   = !snp_pend;
        bus_cmd_o   = BC_WBACK;
        bus_addr_o  = {cl_tag, cpu_idx};
        bus_wdata_o = cl_data;
        if (snp_pend) fsm_d = F_IDLE;
        else if (bus_gnt_i) begin
          wr_en = 1'b1;
          wr_st = LS_I;
          fsm_d = F_MISS;
        end
      end
      F_MISS: begin
        bus_req_o  = !snp_pend;
        bus_cmd_o  = cpu_we_i ? BC_WRMISS : BC_RDMISS;
        bus_addr_o = cpu_addr_i;
        if (snp_pend) fsm_d = F_IDLE;
        else if (bus_gnt_i) begin
          wr_en       = 1'b1;
          wr_tag      = cpu_tag;
          wr_st       = cpu_we_i ? LS_E : LS_S;
          wr_data     = cpu_we_i ? cpu_wdata_i : bus_rdata_i;
          cpu_done_o  = 1'b1;
          cpu_rdata_o = bus_rdata_i;
          fsm_d       = F_IDLE;
        end
      end
      default: fsm_d = F_IDLE;
    endcase
  end

  logic [IDX_W-1:0] snp_idx_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) snp_idx_q <= '0;
    else         snp_idx_q <= snp_idx;
  end

  a_r5_hit_no_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o && !bus_gnt_i |-> !bus_req_o);
  a_r4_wback_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && (bus_cmd_o == BC_RDMISS || bus_cmd_o == BC_WRMISS) |-> !victim_dirty);
  a_r9_fill_on_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en && fsm_q != F_IDLE |-> bus_gnt_i && !snp_pend);
  a_r10_snoop_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && snp_pend |-> !cpu_done_o);
  a_r7_owner_gives_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_abort_o |=> line_st[snp_idx_q] != LS_E);
  a_r11_done_has_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |-> cpu_req_i);
endmodule

// File: tb/test_msi_snoop_ctrl.sv
`timescale 1ns/1ps
module test_msi_snoop_ctrl;
  localparam int ADDR_W = 8, IDX_W = 2, DATA_W = 16, LINES = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0;
  logic [ADDR_W-1:0] cpu_addr = '0, snp_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic [DATA_W-1:0] cpu_rdata, bus_wdata, bus_rdata, snp_data;
  logic cpu_done, bus_req, bus_gnt = 0, snp_abort;
  logic [1:0] bus_cmd, snp_cmd = 2'd0;
  logic [ADDR_W-1:0] bus_addr;

  msi_snoop_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) i_msi_snoop_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_rdata_o(cpu_rdata), .cpu_done_o(cpu_done),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr), .snp_abort_o(snp_abort), .snp_data_o(snp_data)
  );

  always #2.5 clk = ~clk;

  logic [DATA_W-1:0] mem [256];
  assign bus_rdata = mem[bus_addr];

  int n_chk = 0, n_bad = 0;
  int rst_s [LINES];
  logic [5:0] rtag [LINES];
  logic [DATA_W-1:0] rdat [LINES];

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic snoop_model(input logic [1:0] c, input logic [7:0] a,
                             output bit ab, output logic [15:0] d, output bit chg);
    int i = int'(a[1:0]);
    ab = 0; chg = 0; d = '0;
    if (rst_s[i] != 0 && rtag[i] == a[7:2]) begin
      if (c == 2'd1 && rst_s[i] == 2) begin
        ab = 1; d = rdat[i]; chg = 1; rst_s[i] = 1;
      end else if (c == 2'd2) begin
        chg = 1; ab = (rst_s[i] == 2);
        if (ab) d = rdat[i];
        rst_s[i] = 0;
      end
    end
  endtask

  // entered and left just after a falling edge
  task automatic do_snoop(input logic [1:0] c, input logic [7:0] a, input string rq);
    bit eab, echg;
    logic [15:0] ed;
    snoop_model(c, a, eab, ed, echg);
    snp_cmd = c; snp_addr = a;
    #1;
    chk(snp_abort == eab, rq, "snoop abort", snp_abort, eab);
    if (eab) begin
      chk(snp_data == ed, rq, "snoop data", snp_data, ed);
      mem[a] = snp_data;
    end
    @(negedge clk);
    snp_cmd = 2'd0;
  endtask

  task automatic cpu_op(input bit we, input logic [7:0] a, input logic [15:0] wd,
                        input int inj_in, input logic [1:0] sc, input logic [7:0] sa, input string rq);
    int i = int'(a[1:0]);
    int inj = inj_in;
    bit match, phit, hit, wb, eab, echg, conflict, done;
    logic [15:0] esd, wbd, erd, got;
    logic [7:0] wba;
    logic [1:0] ecmd;
    logic [1:0] lc [4];
    logic [7:0] la [4];
    logic [15:0] ld [4];
    int nl, cyc, wait_cnt, done_cyc, en;
    match = rst_s[i] != 0 && rtag[i] == a[7:2];
    phit = we ? (rst_s[i] == 2 && match) : match;
    if (inj == 1 && phit) inj = -1;
    conflict = 0; eab = 0; esd = '0;
    if (inj >= 0) begin
      snoop_model(sc, sa, eab, esd, echg);
      conflict = (inj == 0) && echg && (sa[1:0] == a[1:0]);
    end
    match = rst_s[i] != 0 && rtag[i] == a[7:2];
    hit = we ? (rst_s[i] == 2 && match) : match;
    wb = !hit && rst_s[i] == 2 && rtag[i] != a[7:2];
    wba = {rtag[i], a[1:0]};
    wbd = rdat[i];
    ecmd = we ? 2'd2 : 2'd1;
    erd = hit ? rdat[i] : ((eab && sa == a) ? esd : mem[a]);
    if (hit) begin
      if (we) rdat[i] = wd;
    end else begin
      rst_s[i] = we ? 2 : 1;
      rtag[i] = a[7:2];
      rdat[i] = we ? wd : erd;
    end

    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    nl = 0; cyc = 0; done = 0; done_cyc = -1; got = '0;
    wait_cnt = int'($urandom % 3);
    while (!done && cyc < 60) begin
      if (cyc == inj) begin
        snp_cmd = sc; snp_addr = sa;
      end else snp_cmd = 2'd0;
      #1;
      bus_gnt = 0;
      if (cyc != inj && bus_req) begin
        if (wait_cnt == 0) bus_gnt = 1;
        else wait_cnt--;
      end
      #1;
      if (cyc == inj) begin
        chk(snp_abort == eab, rq, "snoop abort during request (R12/R7/R8)", snp_abort, eab);
        if (eab) begin
          chk(snp_data == esd, rq, "snoop data during request", snp_data, esd);
          mem[sa] = snp_data;
        end
        if (conflict) chk(!cpu_done, "R10", "completion in snoop cycle", cpu_done, 0);
      end
      if (bus_gnt && bus_req) begin
        if (nl < 4) begin
          lc[nl] = bus_cmd; la[nl] = bus_addr; ld[nl] = bus_wdata;
        end
        nl++;
        if (bus_cmd == 2'd3) mem[bus_addr] = bus_wdata;
        wait_cnt = int'($urandom % 3);
      end
      if (cpu_done) begin
        done = 1; done_cyc = cyc; got = cpu_rdata;
      end
      @(negedge clk);
      cyc++;
    end
    cpu_req = 0; bus_gnt = 0; snp_cmd = 2'd0;

    chk(done, rq, "request completed", done, 1);
    en = hit ? 0 : (wb ? 2 : 1);
    chk(nl == en, rq, "granted command count", nl, en);
    if (nl == en && wb) begin
      chk(lc[0] == 2'd3, "R4", "write-back command", lc[0], 3);
      chk(la[0] == wba, "R4", "write-back address", la[0], wba);
      chk(ld[0] == wbd, "R4", "write-back data", ld[0], wbd);
    end
    if (nl == en && !hit) begin
      chk(lc[en-1] == ecmd, rq, "miss command (R11 code)", lc[en-1], ecmd);
      chk(la[en-1] == a, "R11", "miss address", la[en-1], a);
    end
    if (!we) chk(got == erd, rq, "read data", got, erd);
    if (hit && !conflict) chk(done_cyc == 0, "R5", "hit completion cycle", done_cyc, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 256; k++) mem[k] = 16'hA000 ^ 16'(k * 37);
    for (int k = 0; k < LINES; k++) begin
      rst_s[k] = 0; rtag[k] = '0; rdat[k] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!cpu_done && !bus_req && !snp_abort, "R1", "outputs idle after reset",
        {cpu_done, bus_req, snp_abort}, 0);

    cpu_op(0, 8'h05, 0, -1, 0, 0, "R1");            // cold read misses
    cpu_op(0, 8'h05, 0, -1, 0, 0, "R2");            // now Shared: hit
    cpu_op(1, 8'h05, 16'h1111, -1, 0, 0, "R3");     // upgrade from Shared
    cpu_op(1, 8'h05, 16'h2222, -1, 0, 0, "R5");     // write hit in Exclusive
    cpu_op(0, 8'h09, 0, -1, 0, 0, "R4");            // evict dirty 0x05
    cpu_op(1, 8'h0D, 16'h3333, -1, 0, 0, "R3");     // Shared other tag: no write-back
    do_snoop(2'd1, 8'h0D, "R7");
    cpu_op(0, 8'h0D, 0, -1, 0, 0, "R7");            // still present as Shared
    cpu_op(1, 8'h0D, 16'h4444, -1, 0, 0, "R7");     // Shared write goes to bus
    do_snoop(2'd2, 8'h0D, "R8");
    cpu_op(0, 8'h0D, 0, -1, 0, 0, "R8");            // invalidated: read miss
    do_snoop(2'd2, 8'h0D, "R6");
    cpu_op(0, 8'h0D, 0, -1, 0, 0, "R6");
    do_snoop(2'd2, 8'h11, "R12");                   // other tag
    do_snoop(2'd3, 8'h0D, "R12");                   // write-back command
    do_snoop(2'd1, 8'h0D, "R12");                   // read miss on Shared
    do_snoop(2'd2, 8'h03, "R12");                   // Invalid line
    cpu_op(0, 8'h0D, 0, -1, 0, 0, "R12");           // still a hit
    cpu_op(1, 8'h02, 16'h5555, -1, 0, 0, "R3");
    cpu_op(0, 8'h06, 0, 1, 2'd1, 8'h02, "R9");      // victim downgraded while waiting
    cpu_op(0, 8'h06, 0, 0, 2'd2, 8'h06, "R10");     // same-cycle snoop on a hit

    for (int n = 0; n < 400; n++) begin
      logic [7:0] a, sa;
      int r, inj;
      a  = {4'd0, 2'($urandom % 3), 2'($urandom % 4)};
      sa = {4'd0, 2'($urandom % 3), 2'($urandom % 4)};
      r = int'($urandom % 10);
      if (r < 4) do_snoop(2'($urandom % 4), sa, "R12");
      else begin
        inj = (r < 6) ? int'($urandom % 2) : -1;
        cpu_op(bit'($urandom % 2), a, 16'($urandom), inj, 2'($urandom % 4), sa, "R9");
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule